// File: doc/BRIEF.md
# Sequential Unsigned Integer Divider

This block divides an unsigned N-bit dividend by an unsigned N-bit divisor over several clock cycles. It keeps one shared shift register pair: a widened partial-remainder half and a quotient half. The quotient half starts out holding the dividend, and quotient bits are shifted into it from the right, one per cycle. A mode input, sampled when the operation starts, selects between two ways of stepping this register.

In restoring mode the block trial-subtracts the divisor on every step and keeps the shifted value when the difference goes negative. In non-restoring mode it lets the partial remainder go negative and chooses add or subtract on the next step from its sign. After N steps, one correction cycle adds the divisor back if the remainder is negative. Both modes give identical results.

A caller presents operands with a one-cycle `start` pulse while the block is idle. It then waits for the single-cycle `done` pulse and reads the quotient and remainder, which stay on the outputs until the next accepted start. A zero divisor is flagged but otherwise runs through the same sequence.

Top module: `seq_divider`

## Requirements
- R1: After reset, busy, done and div_by_zero are 0, and quotient and remainder are 0.
- R2: A start seen at a rising edge while busy is 0 is accepted. Busy is 1 from the next cycle on, for exactly N+2 cycles.
- R3: Done is 1 for exactly one cycle, in the first cycle after busy falls, which is N+2 rising edges after the accepting edge. Busy is 0 whenever done is 1.
- R4: With mode = 0 (restoring) and a nonzero divisor, when done is 1 the quotient equals floor(dividend/divisor) and the remainder equals dividend mod divisor.
- R5: With mode = 1 (non-restoring) and a nonzero divisor, the results are the same as in R4 for every operand pair.
- R6: The final remainder always lies in 0 to divisor-1. In non-restoring mode a negative partial remainder is corrected by one extra addition of the divisor before done.
- R7: With a zero divisor, when done is 1, div_by_zero is 1, the quotient is all ones and the remainder equals the dividend, in both modes.
- R8: A start, operand or mode change while busy is 1 has no effect on the operation in progress or on its results.
- R9: Quotient, remainder and div_by_zero hold their values from done until the next accepted start.
- R10: div_by_zero is cleared by the next accepted start with a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (taken only while idle) |
| mode | input | 1 | 0 = restoring, 1 = non-restoring |
| dividend | input | N | Unsigned dividend |
| divisor | input | N | Unsigned divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | N | Unsigned quotient |
| remainder | output | N | Unsigned remainder |
| div_by_zero | output | 1 | Divisor was zero for the last operation |

## Verification
A wrong quotient bit or a missed add/subtract choice in any step carries through to the final register contents. It therefore shows at the ports only when done rises, N+2 cycles after start, as a quotient/remainder pair that breaks quotient*divisor+remainder = dividend or leaves the remainder outside 0 to divisor-1. The vectors pair each operand set with both modes and include cases that end with a negative partial remainder, so a broken correction step shows as a remainder off by exactly the divisor. A miscounted step counter shows one cycle earlier or later as a shifted done pulse. Operands changed mid-run show as a wrong final result.

// File: rtl/div_pkg.sv
package div_pkg;
   typedef enum logic {
      ALG_RESTORE = 1'b0,
      ALG_NONREST = 1'b1
   } div_alg_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ITER = 2'd1,
      ST_FIX  = 2'd2,
      ST_FIN  = 2'd3
   } div_state_e;
endpackage

// File: rtl/div_addsub.sv
// W-bit add/subtract unit: y = a + b (sub=0) or a - b (sub=1).
// RIPPLE selects an explicit full-adder chain or a plain adder.
module div_addsub #(
   parameter int W      = 10,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);
   logic [W-1:0] b_x;
   assign b_x = b ^ {W{sub}};

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = sub;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign y[i]    = a[i] ^ b_x[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b_x[i]) | (cy[i] & (a[i] ^ b_x[i]));
         end
      end else begin : g_fast
         assign y = a + b_x + {{(W-1){1'b0}}, sub};
      end
   endgenerate
endmodule

// File: rtl/div_step.sv
// One iteration of the division: shift left, add or subtract, form a quotient bit.
module div_step
   import div_pkg::*;
#(
   parameter int N      = 8,
   parameter bit RIPPLE = 1'b0,
   localparam int RW    = N + 2
) (
   input  logic [RW-1:0] r_in,
   input  logic [N-1:0]  q_in,
   input  logic [N-1:0]  d,
   input  div_alg_e      alg,
   output logic [RW-1:0] r_out,
   output logic [N-1:0]  q_out
);
   logic [RW-1:0] r_sh;
   logic [RW-1:0] d_ext;
   logic [RW-1:0] r_try;
   logic          do_sub;
   logic          qbit;

   assign r_sh   = {r_in[RW-2:0], q_in[N-1]};
   assign d_ext  = {2'b00, d};
   // restoring always subtracts; non-restoring picks by the previous sign
   assign do_sub = (alg == ALG_RESTORE) ? 1'b1 : ~r_in[RW-1];

   div_addsub #(.W(RW), .RIPPLE(RIPPLE)) u_as (
      .a(r_sh), .b(d_ext), .sub(do_sub), .y(r_try)
   );

   always_comb begin
      if (alg == ALG_RESTORE) begin
         qbit  = ~r_try[RW-1];
         r_out = r_try[RW-1] ? r_sh : r_try;
      end else begin
         qbit  = ~r_try[RW-1];
         r_out = r_try;
      end
   end

   assign q_out = {q_in[N-2:0], qbit};
endmodule

// File: rtl/div_ctrl.sv
// Sequencer: N iteration cycles, one correction cycle, one finish cycle.
module div_ctrl
   import div_pkg::*;
#(
   parameter int N   = 8,
   localparam int CW = $clog2(N + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic iter_en,
   output logic fix_en,
   output logic busy,
   output logic done
);
   localparam logic [CW-1:0] LAST = CW'(N - 1);

   div_state_e    st_q;
   logic [CW-1:0] cnt_q;

   assign load    = (st_q == ST_IDLE) && start;
   assign iter_en = (st_q == ST_ITER);
   assign fix_en  = (st_q == ST_FIX);
   assign busy    = (st_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= (st_q == ST_FIN);
         unique case (st_q)
            ST_IDLE: if (start) begin
               st_q  <= ST_ITER;
               cnt_q <= '0;
            end
            ST_ITER: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST) st_q <= ST_FIX;
            end
            ST_FIX:  st_q <= ST_FIN;
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
   import div_pkg::*;
#(
   parameter int N      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         mode,
   input  logic [N-1:0] dividend,
   input  logic [N-1:0] divisor,
   output logic         busy,
   output logic         done,
   output logic [N-1:0] quotient,
   output logic [N-1:0] remainder,
   output logic         div_by_zero
);
   localparam int RW = N + 2;

   generate
      if (N < 2) begin : g_bad_width
         $error("seq_divider: N must be at least 2");
      end
   endgenerate

   logic          load, iter_en, fix_en;
   logic [RW-1:0] r_q, r_nx, r_fix;
   logic [N-1:0]  q_q, q_nx, d_q;
   div_alg_e      alg_q;
   logic          dz_q;

   div_ctrl #(.N(N)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load), .iter_en(iter_en), .fix_en(fix_en),
      .busy(busy), .done(done)
   );

   div_step #(.N(N), .RIPPLE(RIPPLE)) u_step (
      .r_in(r_q), .q_in(q_q), .d(d_q), .alg(alg_q),
      .r_out(r_nx), .q_out(q_nx)
   );

   div_addsub #(.W(RW), .RIPPLE(RIPPLE)) u_fix (
      .a(r_q), .b({2'b00, d_q}), .sub(1'b0), .y(r_fix)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_q   <= '0;
         q_q   <= '0;
         d_q   <= '0;
         alg_q <= ALG_RESTORE;
         dz_q  <= 1'b0;
      end else if (load) begin
         r_q   <= '0;
         q_q   <= dividend;
         d_q   <= divisor;
         alg_q <= div_alg_e'(mode);
         dz_q  <= (divisor == '0);
      end else if (iter_en) begin
         r_q <= r_nx;
         q_q <= q_nx;
      end else if (fix_en && r_q[RW-1]) begin
         r_q <= r_fix;
      end
   end

   assign quotient    = q_q;
   assign remainder   = r_q[N-1:0];
   assign div_by_zero = dz_q;
endmodule

// File: rtl/div_check.sv
module div_check #(
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [N-1:0] dividend,
   input logic [N-1:0] divisor,
   input logic         busy,
   input logic         done,
   input logic [N-1:0] quotient,
   input logic [N-1:0] remainder,
   input logic         div_by_zero
);
   localparam int CW = $clog2(N + 4) + 1;

   logic [N-1:0]   op_a, op_b;
   logic [CW-1:0]  busy_cnt;
   logic [2*N:0]   recon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_a     <= '0;
         op_b     <= '0;
         busy_cnt <= '0;
      end else if (start && !busy) begin
         op_a     <= dividend;
         op_b     <= divisor;
         busy_cnt <= '0;
      end else if (busy) begin
         busy_cnt <= busy_cnt + 1'b1;
      end
   end

   assign recon = (2*N+1)'(quotient) * (2*N+1)'(op_b) + (2*N+1)'(remainder);

   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_cnt == CW'(N + 2)));
   assert_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_b != '0) |-> (recon == (2*N+1)'(op_a)) && !div_by_zero);
   assert_rem_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_b != '0) |-> (remainder < op_b));
   assert_zero_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_b == '0) |-> div_by_zero && (quotient == '1) && (remainder == op_a));
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(quotient) && $stable(remainder) && $stable(div_by_zero));
endmodule

bind seq_divider div_check #(.N(N)) u_div_check (
   .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
   .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
   .div_by_zero(div_by_zero)
);

// File: tb/test_seq_divider.sv
module test_seq_divider;
   localparam int N  = 8;
   localparam int NV = 14;
   // vector layout: {mode, dividend, divisor}
   localparam logic [2*N:0] VEC [NV] = '{
      {1'b0, 8'd8,   8'd3},   {1'b1, 8'd8,   8'd3},
      {1'b0, 8'd255, 8'd1},   {1'b1, 8'd255, 8'd1},
      {1'b0, 8'd255, 8'd255}, {1'b1, 8'd255, 8'd255},
      {1'b0, 8'd5,   8'd200}, {1'b1, 8'd5,   8'd200},
      {1'b0, 8'd200, 8'd7},   {1'b1, 8'd200, 8'd7},
      {1'b0, 8'd0,   8'd9},   {1'b1, 8'd100, 8'd10},
      {1'b0, 8'd254, 8'd127}, {1'b1, 8'd129, 8'd128}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         mode = 1'b0;
   logic [N-1:0] dividend = '0;
   logic [N-1:0] divisor = '0;
   logic         busy, done, div_by_zero;
   logic [N-1:0] quotient, remainder;

   int n_checks = 0;
   int n_errors = 0;

   always #10 clk = ~clk;

   seq_divider #(.N(N)) i_seq_divider (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .dividend(dividend), .divisor(divisor),
      .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
      .div_by_zero(div_by_zero)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_div(input logic m, input logic [N-1:0] a, input logic [N-1:0] b,
                          input bit poke);
      int k;
      logic [N-1:0] eq, er;
      string rq;
      rq = (b == 0) ? "R7" : (m ? "R5" : "R4");
      eq = (b == 0) ? '1 : N'(a / b);
      er = (b == 0) ? a : N'(a % b);
      @(negedge clk);
      mode = m; dividend = a; divisor = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 1;
      check(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
      if (poke) begin
         // R8: new request and operands while busy must be ignored
         start = 1'b1; mode = ~m; dividend = ~a; divisor = b ^ 8'h5a;
         @(negedge clk);
         k++;
         start = 1'b0;
      end
      while (!done && k < 60) begin
         @(negedge clk);
         k++;
      end
      check(k == N + 3, "R3", "done latency", k, N + 3);
      check(busy === 1'b0, "R3", "busy low with done", int'(busy), 0);
      check(quotient === eq, poke ? "R8" : rq, "quotient", int'(quotient), int'(eq));
      check(remainder === er, poke ? "R8" : rq, "remainder", int'(remainder), int'(er));
      check(div_by_zero === (b == 0), (b == 0) ? "R7" : "R10", "div_by_zero flag",
            int'(div_by_zero), int'(b == 0));
      if (b != 0)
         check(remainder < b, "R6", "remainder below divisor", int'(remainder), int'(b));
      @(negedge clk);
      check(done === 1'b0, "R3", "done single cycle", int'(done), 0);
      repeat (2) @(negedge clk);
      check(quotient === eq && remainder === er, "R9", "results held",
            int'(quotient), int'(eq));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset",
            int'({busy, done}), 0);
      check(quotient === '0 && remainder === '0 && div_by_zero === 1'b0, "R1",
            "outputs in reset", int'(quotient), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy === 1'b0, "R1", "idle after reset", int'(busy), 0);

      for (int i = 0; i < NV; i++)
         run_div(VEC[i][2*N], VEC[i][2*N-1:N], VEC[i][N-1:0], 1'b0);

      // R7 zero divisor in both modes, then R10 flag cleared by a normal run
      run_div(1'b0, 8'd77, 8'd0, 1'b0);
      run_div(1'b1, 8'd200, 8'd0, 1'b0);
      run_div(1'b1, 8'd77, 8'd5, 1'b0);

      // R8 mid-operation disturbance in each mode
      run_div(1'b0, 8'd250, 8'd13, 1'b1);
      run_div(1'b1, 8'd123, 8'd11, 1'b1);

      // R5 mode equivalence sweep over a grid of operands
      for (int a = 0; a < 256; a += 37) begin
         for (int b = 1; b < 256; b += 51) begin
            run_div(1'b1, 8'(a), 8'(b), 1'b0);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule